// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. It also manages how those offsets are written. While master reset is held, a mode pin (`load_n`) is sampled on every clock edge. The value it has when reset is released fixes two things until the next reset: the default offsets, and which loading method is allowed.

In serial mode, a bit stream on `ser_in` programs both offsets. The block takes one bit per write-clock edge, almost-empty value first and least significant bit first. In parallel mode, strobed writes from `din` alternate between the two registers. In both modes the offsets can be read back on `dout`, one register per read strobe, in alternating order. The two offsets are driven continuously to the flag comparators, which lie outside this block.

Top module: `flag_offset_prog`

## Requirements
- R1: When reset is released with `load_n` low at the last reset edge, both offsets equal 127 and `serial_mode` is 0 (parallel loading).
- R2: When reset is released with `load_n` high at the last reset edge, both offsets equal 1023 and `serial_mode` is 1 (serial loading).
- R3: In serial mode, each edge with `load_n` and `ser_en_n` both low shifts `ser_in` into a 2*OFS_W-bit chain. After 2*OFS_W such edges, the first OFS_W bits form `ae_off` and the next OFS_W bits form `af_off`, each least significant bit first.
- R4: In serial mode, an edge with `ser_en_n` high or `load_n` high leaves both offsets unchanged.
- R5: `serial_mode` changes only during reset. In serial mode, parallel write strobes have no effect. In parallel mode, serial enable has no effect.
- R6: In parallel mode, an edge with `load_n` and `wr_en_n` both low writes `din` into one offset. Writes alternate almost-empty, almost-full, almost-empty and so on, starting at almost-empty after reset.
- R7: In either mode, an edge with `load_n` and `rd_en_n` both low loads `dout` with one offset. Reads alternate almost-empty then almost-full, starting at almost-empty after reset, using a pointer separate from the write pointer. Otherwise `dout` holds its value, and it is 0 after reset.
- R8: When a parallel write and a read occur on the same edge, `dout` receives the value the selected register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| load_n | input | 1 | Mode select during reset; load strobe afterwards, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_in | input | 1 | Serial programming data |
| wr_en_n | input | 1 | Parallel write enable, active low |
| rd_en_n | input | 1 | Parallel readback enable, active low |
| din | input | OFS_W | Parallel offset data |
| dout | output | OFS_W | Readback data |
| ae_off | output | OFS_W | Almost-empty threshold |
| af_off | output | OFS_W | Almost-full threshold |
| serial_mode | output | 1 | 1 when serial loading was selected at reset |

## Verification
A write and a readback can fall on the same edge. In parallel mode both can also hit the same register at once, since the two pointers advance independently. The bench drives `wr_en_n` and `rd_en_n` low together while both pointers select almost-empty, and again while both select almost-full. It then checks that `dout` carries the value from before the write, while the offset output shows the new value. Readback alongside serial mode is also exercised, to confirm that reading never disturbs the programmed offsets.

// File: rtl/flag_offset_prog.sv
module flag_offset_prog #(
  parameter int OFS_W    = 10,
  parameter int DEF_NEAR = 127,
  parameter int DEF_FAR  = 1023
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             load_n,
  input  logic             ser_en_n,
  input  logic             ser_in,
  input  logic             wr_en_n,
  input  logic             rd_en_n,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] dout,
  output logic [OFS_W-1:0] ae_off,
  output logic [OFS_W-1:0] af_off,
  output logic             serial_mode
);

  localparam int CHAIN_W = 2 * OFS_W;
  localparam logic [OFS_W-1:0] NEAR_V = OFS_W'(DEF_NEAR);
  localparam logic [OFS_W-1:0] FAR_V  = OFS_W'(DEF_FAR);

  logic wsel, rsel;
  logic [CHAIN_W-1:0] chain, chain_nxt;

  wire do_shift = serial_mode & ~load_n & ~ser_en_n;
  wire do_pwr   = ~serial_mode & ~load_n & ~wr_en_n;
  wire do_rd    = ~load_n & ~rd_en_n;

  assign chain     = {af_off, ae_off};
  assign chain_nxt = {ser_in, chain[CHAIN_W-1:1]};

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      serial_mode <= load_n;
      ae_off      <= load_n ? FAR_V : NEAR_V;
      af_off      <= load_n ? FAR_V : NEAR_V;
      wsel        <= 1'b0;
      rsel        <= 1'b0;
      dout        <= '0;
    end else begin
      if (do_shift) begin
        {af_off, ae_off} <= chain_nxt;
      end else if (do_pwr) begin
        if (wsel) af_off <= din;
        else      ae_off <= din;
        wsel <= ~wsel;
      end
      if (do_rd) begin
        dout <= rsel ? af_off : ae_off;
        rsel <= ~rsel;
      end
    end
  end

  AST_DEFAULT_NEAR: assert property (@(posedge clk) disable iff (!mrst_n)
    ($past(!mrst_n) && !$past(load_n)) |-> (ae_off == NEAR_V && af_off == NEAR_V && !serial_mode)); // R1
  AST_DEFAULT_FAR: assert property (@(posedge clk) disable iff (!mrst_n)
    ($past(!mrst_n) && $past(load_n)) |-> (ae_off == FAR_V && af_off == FAR_V && serial_mode)); // R2
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    (serial_mode && (ser_en_n || load_n)) |=> ($stable(ae_off) && $stable(af_off))); // R4
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(serial_mode)); // R5
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    (!serial_mode && (load_n || wr_en_n)) |=> ($stable(ae_off) && $stable(af_off))); // R6
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    (load_n || rd_en_n) |=> $stable(dout)); // R7

endmodule

// File: tb/flag_offset_prog_test.sv
module flag_offset_prog_test;
  localparam int W = 10;

  logic clk = 1'b0;
  logic mrst_n, load_n, ser_en_n, ser_in, wr_en_n, rd_en_n;
  logic [W-1:0] din, dout, ae_off, af_off;
  logic serial_mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_offset_prog #(.OFS_W(W), .DEF_NEAR(127), .DEF_FAR(1023)) uut (
    .clk(clk), .mrst_n(mrst_n), .load_n(load_n), .ser_en_n(ser_en_n),
    .ser_in(ser_in), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .din(din),
    .dout(dout), .ae_off(ae_off), .af_off(af_off), .serial_mode(serial_mode));

  // {wr_en_n, rd_en_n, din, exp_ae, exp_af, exp_dout}, load_n held low, parallel mode
  localparam int VN = 9;
  localparam logic [41:0] VEC [VN] = '{
    {1'b0, 1'b1, 10'd5,    10'd5,    10'd127,  10'd0},
    {1'b0, 1'b1, 10'd900,  10'd5,    10'd900,  10'd0},
    {1'b1, 1'b0, 10'd0,    10'd5,    10'd900,  10'd5},
    {1'b1, 1'b0, 10'd0,    10'd5,    10'd900,  10'd900},
    {1'b0, 1'b0, 10'd33,   10'd33,   10'd900,  10'd5},
    {1'b0, 1'b0, 10'd1023, 10'd33,   10'd1023, 10'd900},
    {1'b1, 1'b1, 10'd7,    10'd33,   10'd1023, 10'd900},
    {1'b1, 1'b0, 10'd0,    10'd33,   10'd1023, 10'd33},
    {1'b1, 1'b0, 10'd0,    10'd33,   10'd1023, 10'd1023}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic se, input logic si,
                      input logic wr, input logic rd, input logic [W-1:0] d);
    @(negedge clk);
    load_n = ld; ser_en_n = se; ser_in = si; wr_en_n = wr; rd_en_n = rd; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    mrst_n = 1'b0; load_n = mode; ser_en_n = 1'b1; ser_in = 1'b0;
    wr_en_n = 1'b1; rd_en_n = 1'b1; din = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mrst_n = 1'b1; load_n = 1'b1;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] stream;
    // parallel mode defaults
    do_reset(1'b0);
    chk("R1 ae", ae_off, 10'd127);
    chk("R1 af", af_off, 10'd127);
    chk("R1 mode", {9'd0, serial_mode}, 10'd0);
    chk("R7 dout reset", dout, 10'd0);

    // serial enable in parallel mode has no effect
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0);
    chk("R5 ae serial ignored", ae_off, 10'd127);
    chk("R5 af serial ignored", af_off, 10'd127);
    // write strobe with load high ignored
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd77);
    chk("R6 load high ae", ae_off, 10'd127);
    chk("R7 load high dout", dout, 10'd0);

    for (int i = 0; i < VN; i++) begin
      step(1'b0, 1'b1, 1'b0, VEC[i][41], VEC[i][40], VEC[i][39:30]);
      chk(i >= 4 && i <= 5 ? "R8 ae" : "R6 ae", ae_off, VEC[i][29:20]);
      chk(i >= 4 && i <= 5 ? "R8 af" : "R6 af", af_off, VEC[i][19:10]);
      chk(i >= 4 && i <= 5 ? "R8 dout" : "R7 dout", dout, VEC[i][9:0]);
    end
    chk("R5 mode lock", {9'd0, serial_mode}, 10'd0);

    // serial mode defaults
    do_reset(1'b1);
    chk("R2 ae", ae_off, 10'd1023);
    chk("R2 af", af_off, 10'd1023);
    chk("R2 mode", {9'd0, serial_mode}, 10'd1);

    // parallel write ignored in serial mode
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd12);
    chk("R5 ae par ignored", ae_off, 10'd1023);
    chk("R5 af par ignored", af_off, 10'd1023);

    stream = {10'h0F3, 10'h2A5};
    for (int i = 0; i < 2 * W; i++) begin
      step(1'b0, 1'b0, stream[i], 1'b1, 1'b1, 10'd0);
      if (i == 9) begin
        // held with serial enable high in the middle of the stream
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'd0);
      end
    end
    chk("R3 ae", ae_off, 10'h2A5);
    chk("R3 af", af_off, 10'h0F3);

    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0);
    chk("R4 ae hold", ae_off, 10'h2A5);
    chk("R4 af hold", af_off, 10'h0F3);

    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0);
    chk("R7 serial read ae", dout, 10'h2A5);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0);
    chk("R7 serial read af", dout, 10'h0F3);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0);
    chk("R7 dout hold", dout, 10'h0F3);
    chk("R5 mode lock serial", {9'd0, serial_mode}, 10'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule